// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block holds the 32-bit control and status word that gathers the completion events of seven DMA channels into one interrupt request for the system interrupt controller. Software uses it to enable channels one at a time, to set one global enable, and to force an interrupt through a bus-error bit. It acknowledges finished channels by writing ones to their flag bits. The channel engines report completion on one input line per channel.

The register sits at offset 0xF4 of the DMA register window and is always readable as a whole word on `icr_rdata`. Each update finds out whether an interrupt is due. The block keeps a sticky "request sent" bit, so the interrupt controller receives exactly one single-cycle pulse each time that bit goes from clear to set. Software re-arms the request with a write that makes the condition false; the sent bit then clears.

Top module: `dma_icr_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000 and `irq_req` is low.
- R2: A write stores bits 0-5 (scratch), bit 15 (forced bus error), bits 16-22 (per-channel enables) and bit 23 (global enable) straight from the write data. Bits 6-14 always read 0.
- R3: A write clears each flag bit 24-30 whose write-data bit is 1 and leaves the flag unchanged where the bit is 0. A write never sets a flag.
- R4: A pulse on `chan_done[n]` sets flag bit 24+n only when enable bit 16+n is set in the updated value.
- R5: After every update, bit 31 equals the interrupt condition: (bit 23 and any of bits 24-30) or bit 15.
- R6: `irq_req` is high for exactly one cycle, in the cycle in which bit 31 first reads 1 after reading 0. It stays low while bit 31 stays set.
- R7: When a write clears a flag in the same cycle that the channel reports completion with its enable set, the flag ends up set.
- R8: Bit 15 forces the condition true whatever the enable and flag bits hold.
- R9: A write that leaves the condition false clears bit 31, so the next time the condition becomes true a new pulse is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icr_wr | input | 1 | Write strobe for the register |
| icr_wdata | input | 32 | Write data |
| chan_done | input | 7 | Per-channel completion pulses |
| icr_rdata | output | 32 | Current register value |
| irq_req | output | 1 | One-cycle request toward the interrupt controller |

## Verification
The bench checks that a write with zeros in the flag field leaves the flags standing. A design that treated the flags as plainly writable would drop pending completions there. It raises the condition again while bit 31 is already set, where a design that keyed the pulse on the condition level would send duplicate requests. It also writes the condition false and then true, which catches a sent bit that never clears and so never re-arms. Two more cases are covered. One is a flag clear that lands on the same cycle as that channel's completion: the wrong write priority loses the event. The other is the bus-error bit with the global enable low: a design that gated it by the enables would stay silent.

// File: rtl/dma_icr_pkg.sv
package dma_icr_pkg;

    localparam int NCH        = 7;
    localparam int TAG_W      = 6;
    localparam int GAP_W      = 9;
    localparam int WORD_W     = 32;
    localparam int FLAG_LSB   = 24;
    localparam int EN_LSB     = 16;
    localparam int GEN_BIT    = 23;
    localparam int BERR_BIT   = 15;
    localparam int SENT_BIT   = 31;
    localparam logic [7:0] ICR_OFFSET = 8'hF4;

    // Field order follows the bit positions software decodes.
    typedef struct packed {
        logic             sent;
        logic [NCH-1:0]   flag;
        logic             gen;
        logic [NCH-1:0]   en;
        logic             berr;
        logic [GAP_W-1:0] gap;
        logic [TAG_W-1:0] tag;
    } icr_word_t;

    typedef struct packed {
        icr_word_t word;
        logic      pulse;
    } icr_state_t;

endpackage

// File: rtl/dma_icr_flag_bank.sv
module dma_icr_flag_bank #(
    parameter int N = 7
) (
    input  logic [N-1:0] flag_old,
    input  logic         wr,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] done,
    input  logic [N-1:0] en_new,
    output logic [N-1:0] flag_new
);
    for (genvar g = 0; g < N; g++) begin : g_chan
        logic kept;
        logic hit;
        always_comb begin
            kept        = flag_old[g] & ~(wr & clr_bits[g]);
            hit         = done[g] & en_new[g];
            flag_new[g] = kept | hit;   // completion wins over acknowledge
        end
    end
endmodule

// File: rtl/dma_icr_cond.sv
module dma_icr_cond #(
    parameter int N = 7
) (
    input  logic         gen,
    input  logic         berr,
    input  logic [N-1:0] flag,
    output logic         cond
);
    always_comb begin
        cond = (gen & (|flag)) | berr;
    end
endmodule

// File: rtl/dma_icr_ctrl.sv
module dma_icr_ctrl
    import dma_icr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                icr_wr,
    input  logic [WORD_W-1:0]   icr_wdata,
    input  logic [NCH-1:0]      chan_done,
    output logic [WORD_W-1:0]   icr_rdata,
    output logic                irq_req
);
    icr_state_t st_d, st_q;
    icr_word_t  wr_word;
    logic [NCH-1:0] en_nx;
    logic [NCH-1:0] flag_nx;
    logic           cond_nx;

    assign wr_word = icr_word_t'(icr_wdata);

    dma_icr_flag_bank #(.N(NCH)) u_flags (
        .flag_old (st_q.word.flag),
        .wr       (icr_wr),
        .clr_bits (wr_word.flag),
        .done     (chan_done),
        .en_new   (en_nx),
        .flag_new (flag_nx)
    );

    dma_icr_cond #(.N(NCH)) u_cond (
        .gen  (icr_wr ? wr_word.gen  : st_q.word.gen),
        .berr (icr_wr ? wr_word.berr : st_q.word.berr),
        .flag (flag_nx),
        .cond (cond_nx)
    );

    always_comb begin
        st_d  = st_q;
        en_nx = icr_wr ? wr_word.en : st_q.word.en;
        if (icr_wr) begin
            st_d.word.tag  = wr_word.tag;
            st_d.word.berr = wr_word.berr;
            st_d.word.en   = wr_word.en;
            st_d.word.gen  = wr_word.gen;
        end
        st_d.word.gap  = '0;
        st_d.word.flag = flag_nx;
        st_d.word.sent = cond_nx;
        st_d.pulse     = cond_nx & ~st_q.word.sent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign icr_rdata = st_q.word;
    assign irq_req   = st_q.pulse;
endmodule

// File: rtl/dma_icr_ctrl_chk.sv
module dma_icr_ctrl_chk
    import dma_icr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] icr_rdata,
    input logic              irq_req
);
    p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        icr_rdata[BERR_BIT-1:TAG_W] == '0);

    p_sent_is_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
        icr_rdata[SENT_BIT] ==
        ((icr_rdata[GEN_BIT] && (|icr_rdata[FLAG_LSB+NCH-1:FLAG_LSB])) || icr_rdata[BERR_BIT]));

    p_pulse_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (icr_rdata[SENT_BIT] && !$past(icr_rdata[SENT_BIT])));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    p_flag_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((icr_rdata[FLAG_LSB+NCH-1:FLAG_LSB] & ~$past(icr_rdata[FLAG_LSB+NCH-1:FLAG_LSB]))
          & ~icr_rdata[EN_LSB+NCH-1:EN_LSB]) == '0);
endmodule

bind dma_icr_ctrl dma_icr_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .icr_rdata (icr_rdata),
    .irq_req   (irq_req)
);

// File: tb/tb_dma_icr_ctrl.sv
module tb_dma_icr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        icr_wr = 1'b0;
    logic [31:0] icr_wdata = '0;
    logic [6:0]  chan_done = '0;
    logic [31:0] icr_rdata;
    logic        irq_req;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_icr_ctrl dut (.*);

    localparam int NV = 16;
    localparam logic        V_WR [NV] = '{1,1,1,0,1,0,0,1,1,0,1,1,1,1,1,1};
    localparam logic [31:0] V_WD [NV] = '{
        32'hFFFF_FFFF, 32'h0000_0000, 32'h0001_0000, 32'h0000_0000,
        32'h0081_0000, 32'h0000_0000, 32'h0000_0000, 32'h0181_0000,
        32'h0183_0000, 32'h0000_0000, 32'h0283_0000, 32'h0003_8000,
        32'h0000_0000, 32'h0080_0000, 32'h0000_0FC0, 32'h7F00_0000};
    localparam logic [6:0]  V_DN [NV] = '{
        7'h00, 7'h00, 7'h00, 7'h03, 7'h00, 7'h00, 7'h01, 7'h00,
        7'h01, 7'h02, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00};
    localparam logic [31:0] V_RD [NV] = '{
        32'h80FF_803F, 32'h0000_0000, 32'h0001_0000, 32'h0101_0000,
        32'h8181_0000, 32'h8181_0000, 32'h8181_0000, 32'h0081_0000,
        32'h8183_0000, 32'h8383_0000, 32'h8183_0000, 32'h8103_8000,
        32'h0100_0000, 32'h8180_0000, 32'h0100_0000, 32'h0000_0000};
    localparam logic        V_IRQ [NV] = '{1,0,0,0,1,0,0,0,1,0,0,0,0,1,0,0};
    // Requirement each vector targets: R8 R9 R2 R4 R5 R6 R6 R3 R7 R4 R5 R8 R9 R9 R2 R3

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [31:0] wd, input logic [6:0] dn);
        @(negedge clk);
        icr_wr = wr; icr_wdata = wd; chan_done = dn;
        @(negedge clk);
        icr_wr = 1'b0; icr_wdata = '0; chan_done = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", icr_rdata, 32'h0);
        check("R1 reset irq", {31'b0, irq_req}, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(V_WR[i], V_WD[i], V_DN[i]);
            check($sformatf("R2-group vec%0d word", i), icr_rdata, V_RD[i]);
            check($sformatf("R6 vec%0d irq", i), {31'b0, irq_req}, {31'b0, V_IRQ[i]});
        end
        // R4: completion on a disabled channel leaves its flag clear
        step(1'b1, 32'h0080_0000, 7'h00);
        step(1'b0, 32'h0, 7'h40);
        check("R4 disabled ch6", icr_rdata, 32'h0080_0000);
        check("R4 no irq", {31'b0, irq_req}, 32'h0);
        // R8: bus error with global enable low still requests
        step(1'b1, 32'h0000_8000, 7'h00);
        check("R8 forced", icr_rdata, 32'h8000_8000);
        check("R8 pulse", {31'b0, irq_req}, 32'h1);
        // R1: reset in the middle of a run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", icr_rdata, 32'h0);
        check("R1 mid-run irq", {31'b0, irq_req}, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule